// File: doc/BRIEF.md
# Conditional Task-Graph Dispatcher

This block sequences one iteration of a fixed task graph. The graph mixes hardware tasks and software tasks. Each hardware task gets its own start pulse and returns its own done bit. Software tasks are launched on a processor through an interrupt. The interrupt comes with a one-hot start vector that names the task to run, and the processor answers on a done vector. Every completion comes back to this block, and nowhere else. The block keeps a sticky record of which tasks have finished and which have been launched. It starts each task as soon as all of its predecessors have finished.

Each task has two kinds of precedence edge. Some edges always apply. The others apply only when the path-select input has a given value. This lets an offline schedule impose one order on the software tasks when the select is 1 and a different order when it is 0. Software tasks form one mutually exclusive set. Only one of them is ever outstanding, and it always runs to completion. An iteration begins on a go pulse while the block is idle. It ends when every task named in the sink mask has finished. At that point all tracking state clears, so the next go starts the graph afresh.

Tasks are numbered with the hardware tasks first (0 to N_HW-1), followed by the software tasks (N_HW to N_HW+N_SW-1). Software task k appears on bit k of the software vectors.

Top module: `cdfg_dispatch`

## Requirements
- R1: While reset is high, and on the first cycle after it, hw_start, sw_start, sw_irq, iter_end and busy are all 0.
- R2: A go input sampled high while busy is 0 raises busy on the next cycle. A go sampled while busy is 1, including on the completion cycle, has no effect on the running iteration.
- R3: Bit i*NT+j of a dependency mask (NT = N_HW+N_SW) means that task i waits for task j. A task starts one cycle after the block is busy and every predecessor selected by the masks is recorded as done. Its start is a pulse one cycle long, and it is started at most once per iteration.
- R4: All hardware tasks that become ready in the same cycle get their start pulses in the same cycle.
- R5: A software launch drives exactly one bit of sw_start for one cycle, and sw_irq is high in that same cycle. When several software tasks are ready, the one with the lowest index is launched.
- R6: While a software task is outstanding, no other software task is launched. A done bit is recorded only for a hardware task that has already been started, or for the outstanding software task. Any other done bit is ignored.
- R7: With path_sel at 1, the always-mask is combined with the select-1 mask. With path_sel at 0, it is combined with the select-0 mask. As a result, the order in which software tasks are launched follows the selected path.
- R8: Once every task in the sink mask is done and no software task is outstanding, iter_end pulses for one cycle and busy falls in that same cycle. All done and launch records clear, and a later go restarts the whole graph.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Source trigger; begins an iteration when idle |
| path_sel | input | 1 | Path-select condition for the conditional edges |
| hw_start | output | N_HW | One-cycle start pulse per hardware task |
| hw_done | input | N_HW | Completion pulse per hardware task |
| sw_start | output | N_SW | One-hot software start vector sent to the processor |
| sw_irq | output | 1 | Interrupt request accompanying a software start |
| sw_done | input | N_SW | Software completion vector from the processor |
| busy | output | 1 | An iteration is in progress |
| iter_end | output | 1 | One-cycle pulse when the iteration completes |

## Verification
The bench runs the graph under both path selections and checks that the software launch order flips between them. A design that ignored the conditional masks would launch in plain index order under both selections. The bench also sends a done for a hardware task that has not yet been started, and a done for a software task that is not outstanding. A design that recorded either one would start a successor early, or would launch a second software task while the first is still running. The bench pulses go in the middle of an iteration and holds go high across a completion. This checks that a running iteration is never restarted, and that a fresh iteration still begins right after the clear. A design that missed either case would show a wrong busy level or start pulses out of step.

// File: rtl/cdfg_pkg.sv
package cdfg_pkg;
  // Largest software-task vector handled by the shared priority helper.
  localparam int MAX_SW = 32;
  typedef logic [MAX_SW-1:0] swvec_t;

  // Keep only the least significant set bit (fixed priority, lowest index).
  function automatic swvec_t keep_lowest(input swvec_t v);
    return v & (~v + swvec_t'(1));
  endfunction
endpackage

// File: rtl/cdfg_ready_eval.sv
module cdfg_ready_eval #(
  parameter int NT = 6,
  parameter logic [NT*NT-1:0] DEP_ALWAYS = '0,
  parameter logic [NT*NT-1:0] DEP_WHEN1  = '0,
  parameter logic [NT*NT-1:0] DEP_WHEN0  = '0
) (
  input  logic          active,
  input  logic          hold,
  input  logic          path_sel,
  input  logic [NT-1:0] done_q,
  input  logic [NT-1:0] issued_q,
  output logic [NT-1:0] ready
);
  // One readiness term per task: its predecessor set is the fixed row
  // plus the row belonging to the currently selected path.
  for (genvar g = 0; g < NT; g++) begin : g_task
    logic [NT-1:0] need;
    assign need = DEP_ALWAYS[g*NT +: NT] |
                  (path_sel ? DEP_WHEN1[g*NT +: NT] : DEP_WHEN0[g*NT +: NT]);
    assign ready[g] = active && !hold && !issued_q[g] &&
                      ((need & ~done_q) == '0);
  end
endmodule

// File: rtl/cdfg_hw_launch.sv
module cdfg_hw_launch #(
  parameter int N_HW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_HW-1:0] ready_hw,
  output logic [N_HW-1:0] launch,
  output logic [N_HW-1:0] start_q
);
  // Hardware tasks have private datapaths: every ready one goes at once.
  assign launch = ready_hw;

  always_ff @(posedge clk) begin
    if (rst) start_q <= '0;
    else     start_q <= launch;
  end

  for (genvar g = 0; g < N_HW; g++) begin : g_chk
    // R3: a start pulse never stretches past one cycle
    a_r3_hw_single_pulse: assert property (@(posedge clk) disable iff (rst)
      start_q[g] |=> !start_q[g]);
  end
endmodule

// File: rtl/cdfg_sw_dispatch.sv
module cdfg_sw_dispatch
  import cdfg_pkg::*;
#(
  parameter int N_SW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [N_SW-1:0] ready_sw,
  input  logic [N_SW-1:0] sw_done,
  output logic [N_SW-1:0] launch,
  output logic [N_SW-1:0] accept,
  output logic            busy,
  output logic [N_SW-1:0] start_q,
  output logic            irq_q
);
  logic [N_SW-1:0] cur_q;
  logic [N_SW-1:0] pick;

  // The outstanding task is held one-hot; an empty vector means idle.
  assign busy   = |cur_q;
  assign accept = sw_done & cur_q;
  assign pick   = N_SW'(keep_lowest(swvec_t'(ready_sw)));
  assign launch = busy ? '0 : pick;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur_q <= '0;
    end else if (launch != '0) begin
      cur_q <= launch;
    end else if (accept != '0) begin
      cur_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      start_q <= launch;
      irq_q   <= |launch;
    end
  end

  // R5: the processor never sees two software starts at once
  a_r5_sw_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start_q));
  // R5: an interrupt always carries exactly one task selection
  a_r5_irq_has_task: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $onehot(start_q));
  // R6: with a task outstanding and no matching done, nothing new launches
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (busy && accept == '0) |=> (start_q == '0));
endmodule

// File: rtl/cdfg_dispatch.sv
module cdfg_dispatch #(
  parameter int N_HW = 3,
  parameter int N_SW = 3,
  parameter logic [(N_HW+N_SW)*(N_HW+N_SW)-1:0] DEP_ALWAYS =
    {6'h00, 6'h01, 6'h00, 6'h12, 6'h00, 6'h00},
  parameter logic [(N_HW+N_SW)*(N_HW+N_SW)-1:0] DEP_WHEN1 =
    {6'h00, 6'h00, 6'h20, 6'h00, 6'h00, 6'h00},
  parameter logic [(N_HW+N_SW)*(N_HW+N_SW)-1:0] DEP_WHEN0 =
    {6'h10, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00},
  parameter logic [N_HW+N_SW-1:0] SINK_DEPS = 6'h3F
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            path_sel,
  output logic [N_HW-1:0] hw_start,
  input  logic [N_HW-1:0] hw_done,
  output logic [N_SW-1:0] sw_start,
  output logic            sw_irq,
  input  logic [N_SW-1:0] sw_done,
  output logic            busy,
  output logic            iter_end
);
  localparam int NT = N_HW + N_SW;

  logic          active_q;
  logic [NT-1:0] done_q;
  logic [NT-1:0] issued_q;
  logic          iter_end_q;
  logic          finish;
  logic [NT-1:0] ready;
  logic [NT-1:0] launch;
  logic [NT-1:0] done_in;
  logic [N_HW-1:0] hw_launch;
  logic [N_SW-1:0] sw_launch;
  logic [N_SW-1:0] sw_accept;
  logic            sw_busy;

  // Sink reached: all its predecessors finished and the processor is free.
  assign finish  = active_q && ((SINK_DEPS & ~done_q) == '0) && !sw_busy;
  assign launch  = {sw_launch, hw_launch};
  // Completions only count for tasks that were actually launched.
  assign done_in = {sw_accept, hw_done & issued_q[N_HW-1:0]};

  cdfg_ready_eval #(
    .NT(NT), .DEP_ALWAYS(DEP_ALWAYS), .DEP_WHEN1(DEP_WHEN1), .DEP_WHEN0(DEP_WHEN0)
  ) u_ready (
    .active(active_q), .hold(finish), .path_sel(path_sel),
    .done_q(done_q), .issued_q(issued_q), .ready(ready)
  );

  cdfg_hw_launch #(.N_HW(N_HW)) u_hw (
    .clk(clk), .rst(rst), .ready_hw(ready[N_HW-1:0]),
    .launch(hw_launch), .start_q(hw_start)
  );

  cdfg_sw_dispatch #(.N_SW(N_SW)) u_sw (
    .clk(clk), .rst(rst), .clr(finish), .ready_sw(ready[NT-1:N_HW]),
    .sw_done(sw_done), .launch(sw_launch), .accept(sw_accept),
    .busy(sw_busy), .start_q(sw_start), .irq_q(sw_irq)
  );

  always_ff @(posedge clk) begin
    if (rst || finish) begin
      active_q <= 1'b0;
      done_q   <= '0;
      issued_q <= '0;
    end else begin
      if (go) active_q <= 1'b1;
      done_q   <= done_q | done_in;
      issued_q <= issued_q | launch;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) iter_end_q <= 1'b0;
    else     iter_end_q <= finish;
  end

  assign busy     = active_q;
  assign iter_end = iter_end_q;

  // R2: an iteration only begins because go was seen
  a_r2_busy_from_go: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go));
  // R8: the cycle after the end pulse carries no start of any kind
  a_r8_quiet_after_end: assert property (@(posedge clk) disable iff (rst)
    iter_end |=> (hw_start == '0 && sw_start == '0 && !sw_irq));
  // R8: the end pulse coincides with the iteration being closed
  a_r8_end_drops_busy: assert property (@(posedge clk) disable iff (rst)
    iter_end |-> !busy);

  for (genvar g = 0; g < NT; g++) begin : g_chk
    logic [NT-1:0] chk_need;
    assign chk_need = DEP_ALWAYS[g*NT +: NT] |
                      (path_sel ? DEP_WHEN1[g*NT +: NT] : DEP_WHEN0[g*NT +: NT]);
    // R3 / R7: a launch is recorded only once the selected predecessors are done
    a_r3_issue_after_preds: assert property (@(posedge clk) disable iff (rst)
      $rose(issued_q[g]) |-> $past((chk_need & ~done_q) == '0));
  end
endmodule

// File: tb/sim_cdfg_dispatch.sv
`timescale 1ns/1ps
module sim_cdfg_dispatch;
  localparam int N_HW = 3;
  localparam int N_SW = 3;
  localparam int NT   = N_HW + N_SW;
  localparam logic [NT*NT-1:0] M_ALW = {6'h00, 6'h01, 6'h00, 6'h12, 6'h00, 6'h00};
  localparam logic [NT*NT-1:0] M_C1  = {6'h00, 6'h00, 6'h20, 6'h00, 6'h00, 6'h00};
  localparam logic [NT*NT-1:0] M_C0  = {6'h10, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00};
  localparam logic [NT-1:0]    M_SNK = 6'h3F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic path_sel = 1'b0;
  logic [N_HW-1:0] hw_start, hw_done;
  logic [N_SW-1:0] sw_start, sw_done;
  logic sw_irq, busy, iter_end;
  logic [N_HW-1:0] resp_hw = '0, inj_hw = '0;
  logic [N_SW-1:0] resp_sw = '0, inj_sw = '0;

  assign hw_done = resp_hw | inj_hw;
  assign sw_done = resp_sw | inj_sw;

  always #2.5 clk = ~clk;

  cdfg_dispatch #(.N_HW(N_HW), .N_SW(N_SW), .DEP_ALWAYS(M_ALW),
    .DEP_WHEN1(M_C1), .DEP_WHEN0(M_C0), .SINK_DEPS(M_SNK)) u0 (
    .clk(clk), .rst(rst), .go(go), .path_sel(path_sel),
    .hw_start(hw_start), .hw_done(hw_done), .sw_start(sw_start),
    .sw_irq(sw_irq), .sw_done(sw_done), .busy(busy), .iter_end(iter_end));

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  int lat [NT] = '{3, 2, 2, 4, 3, 5};
  int cnt [NT];
  int order_q [$];

  // Behavioural reference state
  bit [NT-1:0] m_done, m_iss;
  bit m_act, m_busy;
  int m_cur;
  bit [N_HW-1:0] e_hw;
  bit [N_SW-1:0] e_sw;
  bit e_irq, e_end;

  function automatic bit [NT-1:0] preds(int i, bit p);
    bit [NT-1:0] r;
    for (int j = 0; j < NT; j++)
      r[j] = M_ALW[i*NT+j] | (p ? M_C1[i*NT+j] : M_C0[i*NT+j]);
    return r;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    bit fin;
    bit [NT-1:0] rdy;
    bit [NT-1:0] dn;
    bit nb;
    if (rst) begin
      m_done = '0; m_iss = '0; m_act = 0; m_busy = 0; m_cur = 0;
      e_hw = '0; e_sw = '0; e_irq = 0; e_end = 0;
    end else begin
      fin = m_act && ((M_SNK & ~m_done) == '0) && !m_busy;
      e_hw = '0; e_sw = '0; e_irq = 0; e_end = fin;
      if (fin) begin
        m_act = 0; m_done = '0; m_iss = '0; m_busy = 0;
      end else begin
        for (int i = 0; i < NT; i++)
          rdy[i] = m_act && !m_iss[i] && ((preds(i, path_sel) & ~m_done) == '0);
        dn = '0;
        for (int i = 0; i < N_HW; i++) dn[i] = hw_done[i] && m_iss[i];
        nb = m_busy;
        if (m_busy && sw_done[m_cur]) begin
          dn[N_HW+m_cur] = 1;
          nb = 0;
        end
        for (int i = 0; i < N_HW; i++)
          if (rdy[i]) begin e_hw[i] = 1; m_iss[i] = 1; end
        if (!m_busy) begin
          for (int k = 0; k < N_SW; k++)
            if (rdy[N_HW+k] && !e_irq) begin
              e_sw[k] = 1; e_irq = 1; m_iss[N_HW+k] = 1; nb = 1; m_cur = k;
            end
        end
        m_busy = nb;
        m_done = m_done | dn;
        if (go) m_act = 1;
      end
    end
  end

  // Compare every cycle, then emulate task latencies from expected starts.
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R3 R4", "hw_start", int'(hw_start), int'(e_hw));
      chk("R5 R6 R7", "sw_start", int'(sw_start), int'(e_sw));
      chk("R5", "sw_irq", int'(sw_irq), int'(e_irq));
      chk("R8", "iter_end", int'(iter_end), int'(e_end));
      chk("R2", "busy", int'(busy), int'(m_act));
      for (int k = 0; k < N_SW; k++) if (sw_start[k]) order_q.push_back(k);
    end
    resp_hw = '0; resp_sw = '0;
    for (int i = 0; i < NT; i++) begin
      if (cnt[i] > 0) begin
        cnt[i]--;
        if (cnt[i] == 0) begin
          if (i < N_HW) resp_hw[i] = 1'b1; else resp_sw[i-N_HW] = 1'b1;
        end
      end
    end
    for (int i = 0; i < N_HW; i++) if (e_hw[i]) cnt[i] = lat[i];
    for (int k = 0; k < N_SW; k++) if (e_sw[k]) cnt[N_HW+k] = lat[N_HW+k];
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_end();
    do @(negedge clk); while (!e_end);
  endtask

  task automatic check_order(string req, int a, int b, int c);
    chk(req, "sw launch count", order_q.size(), 3);
    if (order_q.size() == 3) begin
      chk(req, "sw order 1st", order_q[0], a);
      chk(req, "sw order 2nd", order_q[1], b);
      chk(req, "sw order 3rd", order_q[2], c);
    end
    order_q.delete();
  endtask

  initial begin
    for (int i = 0; i < NT; i++) cnt[i] = 0;
    repeat (3) step();
    @(negedge clk);
    // R1: quiet outputs while in reset
    chk("R1", "outputs in reset", int'({hw_start, sw_start, sw_irq, iter_end, busy}), 0);
    step();
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "outputs after reset", int'({hw_start, sw_start, sw_irq, iter_end, busy}), 0);

    // Path 1: software order 2,0,1; with spurious dones and a go mid-run
    path_sel = 1'b1;
    step(); go = 1'b1;
    step(); go = 1'b0;
    step(); step();
    inj_hw = 3'b100;              // R6: task 2 not yet started
    inj_sw = 3'b001;              // R6: software 0 not outstanding
    go = 1'b1;                    // R2: ignored while busy
    step();
    inj_hw = '0; inj_sw = '0; go = 1'b0;
    wait_end();
    check_order("R7", 2, 0, 1);

    // Path 0: software order 0,1,2
    repeat (3) step();
    path_sel = 1'b0;
    go = 1'b1;
    step(); go = 1'b0;
    wait_end();
    check_order("R7", 0, 1, 2);

    // R8: go held across completion restarts the graph
    step(); path_sel = 1'b1; go = 1'b1;
    wait_end();
    check_order("R8", 2, 0, 1);
    step(); go = 1'b0;
    wait_end();
    check_order("R8", 2, 0, 1);
    repeat (4) step();
    @(negedge clk);
    chk("R8", "idle after restart run", int'(busy), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule